// File: doc/BRIEF.md
# Chained 8x8 Multiply-Accumulate Unit

This unit serves a small accumulator-based processor. It multiplies an 8-bit operand by a byte held in a multiplicand register and returns a 16-bit result. The high byte goes to a high-product register and the low byte goes back to the accumulator. There are two operations. A plain multiply first copies the accumulator into the multiplicand register and then multiplies by it. A multiply-add adds the current high-product byte into a new product against the stored multiplicand.

Because the old high byte is folded into each new partial product, a multi-byte number can be multiplied by one byte with one multiply-add per byte. The program adds each low byte into a destination with its own add-with-carry, which gives an accumulated N-by-8 product with no extra hardware. The multiplicand register can also be written directly, so one multiplier byte can be reused across a whole row. The product is formed by a shift-and-add engine that retires two multiplier bits per clock, so a result is ready four clocks after the operation is accepted.

Top module: `mac8_chain`

## Requirements
- R1: An accepted start with `op_sel`=0 (plain multiply) loads `acc_in` into the multiplicand register at that edge. When done, {`hi_out`,`acc_out`} = `operand` * `acc_in`.
- R2: An accepted start with `op_sel`=1 (multiply-add) yields {`hi_out`,`acc_out`} = `hi_out` (value at acceptance) + `operand` * multiplicand register (value at acceptance).
- R3: `mreg_we` loads `mreg_din` into the multiplicand register at the next edge. If an accepted plain multiply falls in the same cycle, that multiply's `acc_in` wins. A multiply-add accepted in the same cycle uses the old value.
- R4: `busy` rises at the edge that accepts a start. `done`, `hi_out` and `acc_out` update exactly 4 clocks after that edge, and `busy` falls at the same edge.
- R5: `done` is a single-cycle pulse, and `hi_out` and `acc_out` change only in the cycle `done` is high.
- R6: A `start` seen while `busy` is high is ignored. The running result is unchanged and no further operation follows.
- R7: Reset clears `hi_out`, `acc_out`, the multiplicand register, `busy` and `done`. A multiply-add issued right after reset therefore returns 0.
- R8: The 16-bit result never overflows (maximum 0xFEFF in use). Chaining the operations with byte-wise add-with-carry gives exact 32x8 accumulated products and exact 16x16 products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request an operation (accepted when not busy) |
| op_sel | input | 1 | 0 = plain multiply, 1 = multiply-add |
| operand | input | 8 | Multiplier operand byte |
| acc_in | input | 8 | Current accumulator value |
| mreg_we | input | 1 | Direct write of the multiplicand register |
| mreg_din | input | 8 | Data for the direct write |
| acc_out | output | 8 | Low result byte for the accumulator |
| hi_out | output | 8 | High-product register |
| mreg_out | output | 8 | Multiplicand register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result pulse |

## Verification
A corrupted partial sum, shift position or step counter shows up four clocks after acceptance as a wrong `acc_out`/`hi_out` pair, or as a `done` pulse in the wrong cycle. Because the high byte feeds the next multiply-add, a bad `hi_out` also spreads into every later byte of a chained product. A wrong multiplicand latch shows on `mreg_out` one clock after the write. The bench compares every port against a behavioural model on each clock, so any of these is reported in the cycle it first appears.

// File: rtl/mac8_chain.sv
module mac8_chain #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_sel,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] acc_in,
  input  logic          mreg_we,
  input  logic [DW-1:0] mreg_din,
  output logic [DW-1:0] acc_out,
  output logic [DW-1:0] hi_out,
  output logic [DW-1:0] mreg_out,
  output logic          busy,
  output logic          done
);
  localparam int STEPS = DW / 2;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0]   cnt_q;
  logic [DW-1:0]   mcand_q, mpl_q, hi_q, w_q, mreg_q;
  logic [2*DW-1:0] sum_q, sum_nxt, ext;
  logic [DW+1:0]   part;
  logic            busy_q, done_q;

  wire accept = start && !busy_q;

  assign part = ({2'b00, mcand_q} & {(DW+2){mpl_q[0]}})
              + ({1'b0, mcand_q, 1'b0} & {(DW+2){mpl_q[1]}});
  assign ext     = {{(DW-2){1'b0}}, part} << {cnt_q, 1'b0};
  assign sum_nxt = sum_q + ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      mcand_q <= '0;
      mpl_q   <= '0;
      sum_q   <= '0;
      hi_q    <= '0;
      w_q     <= '0;
      mreg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        mcand_q <= operand;
        mpl_q   <= op_sel ? mreg_q : acc_in;
        sum_q   <= op_sel ? {{DW{1'b0}}, hi_q} : '0;
      end else if (busy_q) begin
        sum_q <= sum_nxt;
        mpl_q <= mpl_q >> 2;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(STEPS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hi_q   <= sum_nxt[2*DW-1:DW];
          w_q    <= sum_nxt[DW-1:0];
        end
      end
      if (accept && !op_sel) mreg_q <= acc_in;
      else if (mreg_we)      mreg_q <= mreg_din;
    end
  end

  assign acc_out  = w_q;
  assign hi_out   = hi_q;
  assign mreg_out = mreg_q;
  assign busy     = busy_q;
  assign done     = done_q;
endmodule

// File: rtl/mac8_chain_chk.sv
module mac8_chain_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          op_sel,
  input logic [DW-1:0] acc_in,
  input logic          mreg_we,
  input logic [DW-1:0] mreg_din,
  input logic [DW-1:0] acc_out,
  input logic [DW-1:0] hi_out,
  input logic [DW-1:0] mreg_out,
  input logic          busy,
  input logic          done
);
  localparam int STEPS = DW / 2;
  int cyc;

  always_ff @(posedge clk) begin
    if (!rst_n)              cyc <= 0;
    else if (start && !busy) cyc <= 0;
    else if (busy)           cyc <= cyc + 1;
  end

  assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == STEPS && !busy));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi_out) && $stable(acc_out)));
  assert_plain_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_sel) |=> (mreg_out == $past(acc_in)));
  assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mreg_we && !(start && !busy && !op_sel)) |=> (mreg_out == $past(mreg_din)));
endmodule

bind mac8_chain mac8_chain_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .acc_in(acc_in),
  .mreg_we(mreg_we), .mreg_din(mreg_din), .acc_out(acc_out), .hi_out(hi_out),
  .mreg_out(mreg_out), .busy(busy), .done(done)
);

// File: tb/mac8_chain_tb_top.sv
`timescale 1ns/1ps
module mac8_chain_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, op_sel, mreg_we;
  logic [7:0] operand, acc_in, mreg_din, acc_out, hi_out, mreg_out;
  logic busy, done;

  mac8_chain dut_i (.clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .operand(operand), .acc_in(acc_in), .mreg_we(mreg_we), .mreg_din(mreg_din),
    .acc_out(acc_out), .hi_out(hi_out), .mreg_out(mreg_out), .busy(busy), .done(done));

  int vecs = 0, errs = 0;
  logic [7:0] m_hi = 0, m_w = 0, m_mreg = 0;
  logic [15:0] m_pend = 0;
  int m_rem = 0;
  logic m_done = 0;

  task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic model_edge();
    logic acc;
    if (!rst_n) begin
      m_hi = 0; m_w = 0; m_mreg = 0; m_rem = 0; m_done = 0;
    end else begin
      acc = start && (m_rem == 0);
      m_done = 0;
      if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) begin
          m_hi = m_pend[15:8]; m_w = m_pend[7:0]; m_done = 1;
        end
      end
      if (acc) begin
        m_pend = op_sel ? 16'(m_hi) + 16'(operand) * 16'(m_mreg)
                        : 16'(operand) * 16'(acc_in);
        m_rem = 4;
      end
      if (acc && !op_sel) m_mreg = acc_in;
      else if (mreg_we)   m_mreg = mreg_din;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1 R2", "acc_out", 64'(acc_out), 64'(m_w));
    chk("R1 R2", "hi_out", 64'(hi_out), 64'(m_hi));
    chk("R3", "mreg_out", 64'(mreg_out), 64'(m_mreg));
    chk("R4", "busy", 64'(busy), 64'(m_rem > 0));
    chk("R5", "done", 64'(done), 64'(m_done));
  endtask

  task automatic issue(input logic op, input logic [7:0] opnd, input logic [7:0] acc,
                       input logic we, input logic [7:0] din,
                       output logic [7:0] lo, output logic [7:0] hi, output int lat);
    start = 1; op_sel = op; operand = opnd; acc_in = acc; mreg_we = we; mreg_din = din;
    step();
    start = 0; mreg_we = 0;
    lat = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      lat++;
      if (done) break;
    end
    lo = acc_out; hi = hi_out;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] lo, hi, r0, r1, r2, r3, q1, q2, q3;
    logic [7:0] p [5];
    int lat;
    rst_n = 0; start = 0; op_sel = 0; operand = 0; acc_in = 0; mreg_we = 0; mreg_din = 0;
    repeat (3) step();
    chk("R7", "reset hi", 64'(hi_out), 0);
    chk("R7", "reset acc", 64'(acc_out), 0);
    chk("R7", "reset mreg", 64'(mreg_out), 0);
    chk("R7", "reset busy/done", 64'({busy, done}), 0);
    rst_n = 1;
    step();

    issue(1, 8'hff, 8'h55, 0, 0, lo, hi, lat);
    chk("R7", "muladd after reset", 64'({hi, lo}), 0);

    issue(0, 8'd200, 8'd150, 0, 0, lo, hi, lat);
    chk("R1", "plain product", 64'({hi, lo}), 64'd30000);
    chk("R1", "mreg copy", 64'(mreg_out), 64'd150);
    chk("R4", "latency", 64'(lat), 4);

    issue(1, 8'd255, 8'h00, 0, 0, lo, hi, lat);
    chk("R2", "muladd product", 64'({hi, lo}), 64'h95DF);

    issue(0, 8'hff, 8'hff, 0, 0, lo, hi, lat);
    issue(1, 8'hff, 8'h00, 0, 0, lo, hi, lat);
    chk("R8", "max result", 64'({hi, lo}), 64'hFEFF);

    issue(0, 8'd3, 8'h11, 1, 8'h22, lo, hi, lat);
    chk("R3", "plain beats write", 64'(mreg_out), 64'h11);
    issue(1, 8'd2, 8'h00, 1, 8'h40, lo, hi, lat);
    chk("R3", "muladd uses old mreg", 64'({hi, lo}), 64'h22);
    chk("R3", "write after muladd", 64'(mreg_out), 64'h40);

    start = 1; op_sel = 0; operand = 8'd7; acc_in = 8'd9; step();
    operand = 8'd100; acc_in = 8'd100; op_sel = 1; step(); step();
    start = 0; step(); step();
    chk("R6", "busy start ignored", 64'({hi_out, acc_out}), 64'd63);
    step();
    chk("R6", "no extra op", 64'(busy), 0);
    chk("R6", "mreg kept", 64'(mreg_out), 64'd9);

    for (int t = 0; t < 20; t++) begin
      logic [31:0] a; logic [7:0] b; logic [39:0] dest, accum; logic [8:0] s;
      a = $urandom; b = 8'($urandom); dest = {8'($urandom), 32'($urandom)};
      issue(0, a[7:0], b, 0, 0, p[0], hi, lat);
      for (int i = 1; i < 4; i++) issue(1, a[8*i +: 8], 8'h00, 0, 0, p[i], hi, lat);
      p[4] = hi;
      chk("R8", "32x8 product", 64'({p[4], p[3], p[2], p[1], p[0]}), 64'(40'(a) * 40'(b)));
      s = 0;
      for (int i = 0; i < 5; i++) begin
        s = 9'(dest[8*i +: 8]) + 9'(p[i]) + 9'(s[8]);
        accum[8*i +: 8] = s[7:0];
      end
      chk("R8", "32x8 accumulate", 64'(accum), 64'(40'(dest + 40'(a) * 40'(b))));
    end

    for (int t = 0; t < 20; t++) begin
      logic [15:0] a, b; logic [31:0] sum;
      a = 16'($urandom); b = 16'($urandom);
      issue(0, b[7:0], a[7:0], 0, 0, r0, hi, lat);
      issue(1, b[15:8], 8'h00, 0, 0, r1, r2, lat);
      issue(0, b[7:0], a[15:8], 0, 0, q1, hi, lat);
      issue(1, b[15:8], 8'h00, 0, 0, q2, q3, lat);
      sum = {8'h00, r2, r1, r0} + {q3, q2, q1, 8'h00};
      r3 = sum[31:24];
      chk("R8", "16x16 product", 64'({r3, sum[23:0]}), 64'(32'(a) * 32'(b)));
    end

    for (int t = 0; t < 3000; t++) begin
      start = ($urandom % 3) == 0; op_sel = 1'($urandom);
      operand = 8'($urandom); acc_in = 8'($urandom);
      mreg_we = ($urandom % 4) == 0; mreg_din = 8'($urandom);
      step();
    end
    start = 0; mreg_we = 0;
    repeat (6) step();
    summary();
  end
endmodule